// File: doc/BRIEF.md
# Sampling Delay Window Finder

This block inspects a pass/fail map with one bit per delay tap (bit n set means tap n sampled correctly) and picks the tap that should be programmed into a sampling delay line. It finds the longest unbroken run of passing taps, reports where that run starts and how long it is, and derives a final tap placed safely inside the run. A controller hands it a finished map together with a one-cycle start strobe. It then receives the window start, the window length and the chosen tap, together with a one-cycle done pulse.

The search is serial. It visits one candidate run start per clock. After each run it jumps forward by the length of that run, or by one tap when the run is empty. It stops as soon as the scan position passes the last tap. It also stops early when a long enough window has been found close to tap 0. A map with no passing tap reports a reserved error code instead of a tap.

Top module: `sdw_window_finder`

## Requirements
- R1: After reset, done_o is 0 and win_start_o, win_len_o and phase_o are all 0.
- R2: For a non-empty map, win_start_o and win_len_o give the first-reached longest run of consecutive 1 bits, where bit n of tap_map_i is tap n. A run ends at tap 31 and never continues into tap 0.
- R3: When two runs are equally long, the earlier one is reported, because a later run replaces the best result only when it is strictly longer.
- R4: The scan starts at tap 0. Each step measures the run at the current position, then advances by that run length, or by 1 when the length is 0. done_o is high in the cycle after the N-th rising edge that follows the edge sampling start_i, where N is the number of steps taken (N = 1 for an empty map).
- R5: The scan ends right after a step whose run is at least 12 taps long while the best start so far is below 4. Longer runs further up the map are then not considered.
- R6: When the reported start is 0 and the length is non-zero, phase_o = floor(len/3) mod 32.
- R7: When the reported start is non-zero, phase_o = (start + floor(len/2)) mod 32.
- R8: An all-zero map reports phase_o = 8'hFF with win_start_o = 0 and win_len_o = 0.
- R9: done_o is high for exactly one cycle per search. win_start_o, win_len_o and phase_o change only in the cycle where done_o rises, and they hold between searches.
- R10: start_i is ignored while a search is running. Such a strobe neither alters the running search nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to search tap_map_i |
| tap_map_i | input | TAPS (32) | Pass/fail map, bit n = tap n passed |
| win_start_o | output | log2(TAPS) (5) | First tap of the reported window |
| win_len_o | output | log2(TAPS+1) (6) | Length of the reported window |
| phase_o | output | PHASE_W (8) | Chosen tap, or 8'hFF for an empty map |
| done_o | output | 1 | One-cycle pulse when results are valid |

## Verification
The result latency depends on the map. The bench's reference model therefore counts the scan steps a map needs and expects done_o exactly that many rising edges after the edge that samples start_i: one edge for an empty map or an immediate early stop, and up to 32 edges for a map whose only passing tap is tap 31. Inputs are driven and outputs sampled on the falling edge, with an edge counter running from the strobe. This fixes the latency exactly and catches any extra or missing cycle. After each result the bench keeps sampling for several more cycles to confirm that done_o has dropped and the outputs hold. A checker bounds the busy time to TAPS+1 cycles.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_t;

   // A division by 3 through reciprocal multiply is exact for 0..32.
   localparam int unsigned RECIP3_MUL   = 43;
   localparam int unsigned RECIP3_SHIFT = 7;
   localparam int unsigned RECIP3_MAX   = 32;

endpackage

// File: rtl/sdw_run_measure.sv
module sdw_run_measure #(
   parameter int TAPS = 32,
   localparam int PW  = $clog2(TAPS),
   localparam int LW  = $clog2(TAPS + 1)
) (
   input  logic [TAPS-1:0] map_i,
   input  logic [PW-1:0]   pos_i,
   output logic [LW-1:0]   run_len_o
);

   logic [TAPS-1:0] shifted;
   logic [TAPS-1:0] unbroken;

   // Bits shifted in from above tap TAPS-1 are zero, so a run stops at the
   // last tap and never wraps to tap 0.
   assign shifted = map_i >> pos_i;

   assign unbroken[0] = shifted[0];
   generate
      for (genvar g = 1; g < TAPS; g++) begin : g_chain
         assign unbroken[g] = unbroken[g-1] & shifted[g];
      end
   endgenerate

   always_comb begin
      run_len_o = '0;
      for (int k = 0; k < TAPS; k++) begin
         run_len_o = run_len_o + LW'(unbroken[k]);
      end
   end

endmodule

// File: rtl/sdw_phase_pick.sv
module sdw_phase_pick #(
   parameter int TAPS           = 32,
   parameter int PHASE_W        = 8,
   parameter int ERR_CODE       = 255,
   parameter bit USE_RECIP_DIV3 = 1'b0,
   localparam int PW = $clog2(TAPS),
   localparam int LW = $clog2(TAPS + 1)
) (
   input  logic [PW-1:0]      win_start_i,
   input  logic [LW-1:0]      win_len_i,
   input  logic               empty_i,
   output logic [PHASE_W-1:0] phase_o
);

   import sdw_pkg::*;

   logic [LW-1:0] third;
   logic [LW-1:0] half;
   logic [LW:0]   offset_sum;
   logic [PW-1:0] wrapped;

   assign half = win_len_i >> 1;

   generate
      if (USE_RECIP_DIV3) begin : g_recip
         logic [LW+7:0] prod;
         assign prod  = {8'd0, win_len_i} * (LW+8)'(RECIP3_MUL);
         assign third = LW'(prod >> RECIP3_SHIFT);
      end else begin : g_divide
         assign third = win_len_i / LW'(3);
      end
   endgenerate

   always_comb begin
      if (win_start_i == '0) begin
         offset_sum = {1'b0, third};
      end else begin
         offset_sum = (LW+1)'(win_start_i) + {1'b0, half};
      end
      wrapped = offset_sum[PW-1:0];
      if (empty_i) begin
         phase_o = PHASE_W'(ERR_CODE);
      end else begin
         phase_o = PHASE_W'(wrapped);
      end
   end

endmodule

// File: rtl/sdw_scan_ctrl.sv
module sdw_scan_ctrl #(
   parameter int TAPS        = 32,
   parameter int PHASE_W     = 8,
   parameter int EARLY_LEN   = 12,
   parameter int EARLY_START = 4,
   localparam int PW = $clog2(TAPS),
   localparam int LW = $clog2(TAPS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [TAPS-1:0]    map_i,
   output logic [TAPS-1:0]    map_q_o,
   output logic [PW-1:0]      pos_o,
   input  logic [LW-1:0]      cur_len_i,
   output logic [PW-1:0]      nxt_start_o,
   output logic [LW-1:0]      nxt_len_o,
   output logic               empty_o,
   input  logic [PHASE_W-1:0] phase_i,
   output logic [PW-1:0]      win_start_o,
   output logic [LW-1:0]      win_len_o,
   output logic [PHASE_W-1:0] phase_o,
   output logic               done_o
);

   import sdw_pkg::*;

   localparam logic [LW:0] TAPS_END = (LW+1)'(TAPS);

   scan_state_t     state_q;
   logic [TAPS-1:0] map_q;
   logic [PW-1:0]   pos_q;
   logic [PW-1:0]   best_start_q;
   logic [LW-1:0]   best_len_q;

   logic            better;
   logic [LW-1:0]   stride;
   logic [LW:0]     pos_next;
   logic            early_stop;
   logic            finish;

   assign map_q_o = map_q;
   assign pos_o   = pos_q;

   always_comb begin
      better      = cur_len_i > best_len_q;
      nxt_start_o = better ? pos_q : best_start_q;
      nxt_len_o   = better ? cur_len_i : best_len_q;
      stride      = (cur_len_i == '0) ? LW'(1) : cur_len_i;
      pos_next    = (LW+1)'(pos_q) + {1'b0, stride};
      early_stop  = (int'(cur_len_i) >= EARLY_LEN) &&
                    (int'(nxt_start_o) < EARLY_START);
      empty_o     = (map_q == '0);
      finish      = empty_o || early_stop || (pos_next >= TAPS_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SCAN_IDLE;
         map_q        <= '0;
         pos_q        <= '0;
         best_start_q <= '0;
         best_len_q   <= '0;
         win_start_o  <= '0;
         win_len_o    <= '0;
         phase_o      <= '0;
         done_o       <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            SCAN_IDLE: begin
               if (start_i) begin
                  map_q        <= map_i;
                  pos_q        <= '0;
                  best_start_q <= '0;
                  best_len_q   <= '0;
                  state_q      <= SCAN_RUN;
               end
            end
            SCAN_RUN: begin
               if (finish) begin
                  win_start_o <= nxt_start_o;
                  win_len_o   <= nxt_len_o;
                  phase_o     <= phase_i;
                  done_o      <= 1'b1;
                  state_q     <= SCAN_IDLE;
               end else begin
                  pos_q        <= pos_next[PW-1:0];
                  best_start_q <= nxt_start_o;
                  best_len_q   <= nxt_len_o;
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdw_window_finder.sv
module sdw_window_finder #(
   parameter int TAPS           = 32,
   parameter int PHASE_W        = 8,
   parameter int ERR_CODE       = 255,
   parameter int EARLY_LEN      = 12,
   parameter int EARLY_START    = 4,
   parameter bit USE_RECIP_DIV3 = 1'b0,
   localparam int PW = $clog2(TAPS),
   localparam int LW = $clog2(TAPS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [TAPS-1:0]    tap_map_i,
   output logic [PW-1:0]      win_start_o,
   output logic [LW-1:0]      win_len_o,
   output logic [PHASE_W-1:0] phase_o,
   output logic               done_o
);

   import sdw_pkg::*;

   generate
      if (TAPS < 2 || (TAPS & (TAPS - 1)) != 0) begin : g_bad_taps
         $error("sdw_window_finder: TAPS must be a power of two >= 2");
      end
      if (PHASE_W < PW) begin : g_bad_phase_w
         $error("sdw_window_finder: PHASE_W too narrow for a tap index");
      end
      if (ERR_CODE < TAPS || ERR_CODE >= (1 << PHASE_W)) begin : g_bad_err
         $error("sdw_window_finder: ERR_CODE must not alias a tap index");
      end
      if (USE_RECIP_DIV3 && TAPS > RECIP3_MAX) begin : g_bad_recip
         $error("sdw_window_finder: reciprocal divide is exact only up to 32 taps");
      end
      if (EARLY_LEN < 1 || EARLY_START < 0) begin : g_bad_early
         $error("sdw_window_finder: bad early stop limits");
      end
   endgenerate

   logic [TAPS-1:0]    map_q;
   logic [PW-1:0]      pos;
   logic [LW-1:0]      cur_len;
   logic [PW-1:0]      nxt_start;
   logic [LW-1:0]      nxt_len;
   logic               empty;
   logic [PHASE_W-1:0] phase_next;

   sdw_scan_ctrl #(
      .TAPS        (TAPS),
      .PHASE_W     (PHASE_W),
      .EARLY_LEN   (EARLY_LEN),
      .EARLY_START (EARLY_START)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .map_i       (tap_map_i),
      .map_q_o     (map_q),
      .pos_o       (pos),
      .cur_len_i   (cur_len),
      .nxt_start_o (nxt_start),
      .nxt_len_o   (nxt_len),
      .empty_o     (empty),
      .phase_i     (phase_next),
      .win_start_o (win_start_o),
      .win_len_o   (win_len_o),
      .phase_o     (phase_o),
      .done_o      (done_o)
   );

   sdw_run_measure #(
      .TAPS (TAPS)
   ) u_run (
      .map_i     (map_q),
      .pos_i     (pos),
      .run_len_o (cur_len)
   );

   sdw_phase_pick #(
      .TAPS           (TAPS),
      .PHASE_W        (PHASE_W),
      .ERR_CODE       (ERR_CODE),
      .USE_RECIP_DIV3 (USE_RECIP_DIV3)
   ) u_pick (
      .win_start_i (nxt_start),
      .win_len_i   (nxt_len),
      .empty_i     (empty),
      .phase_o     (phase_next)
   );

endmodule

// File: rtl/sdw_checker.sv
module sdw_checker #(
   parameter int TAPS     = 32,
   parameter int PHASE_W  = 8,
   parameter int ERR_CODE = 255,
   localparam int PW = $clog2(TAPS),
   localparam int LW = $clog2(TAPS + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [PW-1:0]      win_start_o,
   input logic [LW-1:0]      win_len_o,
   input logic [PHASE_W-1:0] phase_o,
   input logic               done_o
);

   logic        armed_q;
   logic [15:0] busy_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         busy_cnt_q <= '0;
      end else begin
         if (done_o) begin
            armed_q <= start_i;
         end else if (start_i) begin
            armed_q <= 1'b1;
         end
         if (armed_q && !done_o) begin
            busy_cnt_q <= busy_cnt_q + 16'd1;
         end else begin
            busy_cnt_q <= '0;
         end
      end
   end

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({win_start_o, win_len_o, phase_o}));

   assert_done_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> armed_q);

   assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (int'(busy_cnt_q) <= TAPS + 1));

   assert_error_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((win_len_o == '0) == (phase_o == PHASE_W'(ERR_CODE))));

   assert_window_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(win_start_o) + int'(win_len_o) <= TAPS));

   assert_phase_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && win_len_o != '0) |->
         ((int'(phase_o) >= int'(win_start_o)) &&
          (int'(phase_o) < int'(win_start_o) + int'(win_len_o))));

endmodule

bind sdw_window_finder sdw_checker #(
   .TAPS     (TAPS),
   .PHASE_W  (PHASE_W),
   .ERR_CODE (ERR_CODE)
) u_sdw_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .win_start_o (win_start_o),
   .win_len_o   (win_len_o),
   .phase_o     (phase_o),
   .done_o      (done_o)
);

// File: tb/tb_sdw_window_finder.sv
module tb_sdw_window_finder;

   logic        clk;
   logic        rst_n;
   logic        start_i;
   logic [31:0] tap_map_i;
   logic [4:0]  win_start_o;
   logic [5:0]  win_len_o;
   logic [7:0]  phase_o;
   logic        done_o;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   sdw_window_finder dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .tap_map_i   (tap_map_i),
      .win_start_o (win_start_o),
      .win_len_o   (win_len_o),
      .phase_o     (phase_o),
      .done_o      (done_o)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   always @(posedge clk) cycles <= cycles + 1;

   initial begin
      wait (cycles >= 20000);
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference model written from the requirements.
   task automatic model(input logic [31:0] m, output int s, output int l,
                        output int p, output int n);
      int pos;
      int len;
      s = 0; l = 0; n = 0; pos = 0;
      if (m == 32'd0) begin
         p = 255; n = 1;
         return;
      end
      while (pos < 32) begin
         len = 0;
         while (pos + len < 32 && m[pos + len]) len++;
         n++;
         if (len > l) begin s = pos; l = len; end
         pos += (len != 0) ? len : 1;
         if (len >= 12 && s < 4) break;
      end
      p = (s == 0) ? (l / 3) % 32 : (s + l / 2) % 32;
   endtask

   // Strobes start with map m; optionally restrobes with map alt while busy.
   task automatic search(input logic [31:0] m, input string req,
                         input bit poke, input logic [31:0] alt);
      int s, l, p, n, lat;
      model(m, s, l, p, n);
      @(negedge clk);
      start_i   = 1'b1;
      tap_map_i = m;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (lat < 100) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (poke && lat <= 3) begin
            start_i   = 1'b1;
            tap_map_i = alt;
         end else begin
            start_i = 1'b0;
         end
         if (done_o) break;
      end
      start_i = 1'b0;
      check(lat == n, {req, " R4"}, "latency", lat, n);
      check(int'(win_start_o) == s, {req, " R2"}, "win_start", win_start_o, s);
      check(int'(win_len_o) == l, {req, " R2"}, "win_len", win_len_o, l);
      check(int'(phase_o) == p, req, "phase", phase_o, p);
   endtask

   task automatic test_reset();
      check(done_o == 1'b0, "R1", "done", done_o, 0);
      check(win_start_o == 5'd0, "R1", "win_start", win_start_o, 0);
      check(win_len_o == 6'd0, "R1", "win_len", win_len_o, 0);
      check(phase_o == 8'd0, "R1", "phase", phase_o, 0);
   endtask

   task automatic test_hold();
      logic [4:0] s0;
      logic [5:0] l0;
      logic [7:0] p0;
      int extra = 0;
      s0 = win_start_o; l0 = win_len_o; p0 = phase_o;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         tap_map_i = ~tap_map_i;
         if (done_o) extra++;
      end
      check(extra == 0, "R9", "done pulses after result", extra, 0);
      check({win_start_o, win_len_o, phase_o} == {s0, l0, p0}, "R9",
            "held outputs", {win_start_o, win_len_o, phase_o}, {s0, l0, p0});
   endtask

   task automatic test_full_map();
      search(32'hFFFF_FFFF, "R6 R5", 1'b0, 32'd0);
   endtask

   task automatic test_last_tap();
      search(32'h8000_0000, "R7", 1'b0, 32'd0);
   endtask

   task automatic test_early_miss();
      search(32'hFFFF_EFFF, "R5 R6", 1'b0, 32'd0);
   endtask

   task automatic test_no_early();
      search(32'hFFFC_FFF0, "R5 R7", 1'b0, 32'd0);
   endtask

   task automatic test_early_start3();
      search(32'h0000_7FF8, "R5 R7", 1'b0, 32'd0);
   endtask

   task automatic test_tie();
      search(32'h00F0_00F0, "R3 R7", 1'b0, 32'd0);
   endtask

   task automatic test_no_wrap();
      search(32'hF000_0003, "R2 R7", 1'b0, 32'd0);
   endtask

   task automatic test_low_byte();
      search(32'h0000_00FF, "R6", 1'b0, 32'd0);
   endtask

   task automatic test_empty();
      search(32'h0000_0000, "R8", 1'b0, 32'd0);
   endtask

   task automatic test_ignore_start();
      int extra = 0;
      search(32'h8000_0000, "R10", 1'b1, 32'hFFFF_FFFF);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done_o) extra++;
      end
      check(extra == 0, "R10", "extra searches", extra, 0);
      check(win_len_o == 6'd1, "R10", "win_len after ignored strobe",
            win_len_o, 1);
   endtask

   initial begin
      rst_n     = 1'b0;
      start_i   = 1'b0;
      tap_map_i = 32'd0;
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_full_map();
      test_hold();
      test_last_tap();
      test_early_miss();
      test_no_early();
      test_early_start3();
      test_tie();
      test_no_wrap();
      test_low_byte();
      test_empty();
      test_hold();
      test_ignore_start();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule